// File: doc/BRIEF.md
# Quad-channel serial DAC register interface

This block is the digital front end of a four-channel, 8-bit multiplying DAC. A host shifts 12-bit frames in over a three-wire serial port (serial clock, data, load strobe). Each frame carries a two-bit channel address and an 8-bit code. The load strobe is level-sensitive. While it is high, frames shift in and the oldest register bit is presented on a serial output, so several devices can be chained or read back. While it is low, the addressed channel register follows the frame's data field, the serial inputs are ignored and the serial output is released. The rising edge of the strobe freezes the channel.

An asynchronous active-low preset input forces every channel to the mid-scale code 0x80. Each channel keeps that code until it is rewritten. A per-channel flag marks the channels that still hold the preset code. The analog conversion is outside this block: each channel is represented only by the code it presents, where code D stands for a fraction D/256 of the reference span.

The serial port signals are sampled in the block's own clock domain. A serial clock rising edge is recognised as a low-to-high change between two consecutive samples.

Top module: `qdac_serial_if`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, every channel code is 0x80, every preset flag is 1 and the shift register holds zero, so `sdo_o` is 0.
- R2: While `ld_i` is high, each serial clock rising edge shifts `sdi_i` into the LSB of a 12-bit shift register. `sdo_o` presents the MSB, which is the bit shifted in 12 edges earlier, and `sdo_oe_o` is 1.
- R3: Within a 12-bit frame sent MSB first, the first two bits are ignored. Next come address bit 1 and address bit 0, then data bits 7 down to 0, with bit 0 shifted last.
- R4: While `ld_i` is low, the channel selected by the address is transparent: its code output equals the frame's data field in the same cycle. Address 0 selects channel 0 (code bits 7:0), 1 selects channel 1 (bits 15:8), 2 selects channel 2 (bits 23:16) and 3 selects channel 3 (bits 31:24). The other channels keep their codes.
- R5: After `ld_i` rises, the written channel keeps its code. No later serial traffic with `ld_i` high changes any channel code.
- R6: While `ld_i` is low, serial clock edges and `sdi_i` have no effect on the shift register, and `sdo_oe_o` is 0.
- R7: While `preset_ni` is low, every channel code is 0x80 and every preset flag is 1, whatever the other inputs are, including during a transparent load. After `preset_ni` is released, the codes stay at 0x80 until a channel is rewritten.
- R8: A channel's preset flag drops to 0 when that channel is written. It stays 0 until the next preset or reset.
- R9: A serial clock held high for many cycles causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; the serial port is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| preset_ni | input | 1 | Asynchronous active-low mid-scale preset of all channels |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data and address input |
| ld_i | input | 1 | Load strobe: high shifts, low loads the addressed channel |
| sdo_o | output | 1 | Serial output, MSB of the shift register |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |
| code_o | output | 32 | Four 8-bit channel codes, channel 0 in the low byte |
| preset_o | output | 4 | Per-channel flag: channel still holds the preset code |

## Verification
The hardest situation to reach from the ports is a load strobe held low while the serial clock keeps toggling. In that state the shift register must stay frozen and the open channel must keep showing the old frame. The bench drives clock pulses and opposite data during the low strobe, then raises it and shifts zeros through. This reads the untouched frame back bit by bit on the serial output. A second hard case is a preset pulled low while a channel is transparent. The bench opens a channel, applies the preset in the middle of the load and checks that the mid-scale code wins over the open channel.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned CH_N    = 4;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned FRAME_W = 12;
endpackage

// File: rtl/qdac_shift.sv
module qdac_shift #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned CODE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              ld_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CODE_W-1:0] data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic               sclk_q;
  logic [FRAME_W-1:0] sh_q;
  logic               shift_en;

  // sclk_q tracks even while ld is low so edges seen then are dropped
  assign shift_en = ld_i & sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (shift_en) sh_q <= {sh_q[FRAME_W-2:0], sdi_i};
    end
  end

  assign data_o   = sh_q[CODE_W-1:0];
  assign addr_o   = sh_q[CODE_W+ADDR_W-1:CODE_W];
  assign sdo_o    = sh_q[FRAME_W-1];
  assign sdo_oe_o = ld_i;
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
  parameter int unsigned CH_N   = 4,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned ADDR_W = $clog2(CH_N),
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1)
) (
  input  logic                     clk_i,
  input  logic                     arst_ni,
  input  logic                     ld_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CODE_W-1:0]        data_i,
  output logic [CH_N*CODE_W-1:0]   code_o,
  output logic [CH_N-1:0]          preset_o
);
  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic [CODE_W-1:0] lat_q;
    logic              flag_q;
    logic              sel;
    logic              open;

    assign sel  = ~ld_i & (addr_i == ADDR_W'(g));
    assign open = sel & arst_ni;

    always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
        lat_q  <= MID;
        flag_q <= 1'b1;
      end else if (sel) begin
        lat_q  <= data_i;
        flag_q <= 1'b0;
      end
    end

    // transparent path while the strobe is low
    assign code_o[g*CODE_W +: CODE_W] = open ? data_i : lat_q;
    assign preset_o[g]                = flag_q & ~open;
  end
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if #(
  parameter int unsigned CH_N    = qdac_pkg::CH_N,
  parameter int unsigned CODE_W  = qdac_pkg::CODE_W,
  parameter int unsigned FRAME_W = qdac_pkg::FRAME_W,
  localparam int unsigned ADDR_W = $clog2(CH_N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   preset_ni,
  input  logic                   sclk_i,
  input  logic                   sdi_i,
  input  logic                   ld_i,
  output logic                   sdo_o,
  output logic                   sdo_oe_o,
  output logic [CH_N*CODE_W-1:0] code_o,
  output logic [CH_N-1:0]        preset_o
);
  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] data;
  logic              bank_rst_n;

  assign bank_rst_n = rst_ni & preset_ni;

  qdac_shift #(
    .FRAME_W(FRAME_W),
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .sdi_i   (sdi_i),
    .ld_i    (ld_i),
    .addr_o  (addr),
    .data_o  (data),
    .sdo_o   (sdo_o),
    .sdo_oe_o(sdo_oe_o)
  );

  qdac_chan_bank #(
    .CH_N  (CH_N),
    .CODE_W(CODE_W)
  ) u_bank (
    .clk_i   (clk_i),
    .arst_ni (bank_rst_n),
    .ld_i    (ld_i),
    .addr_i  (addr),
    .data_i  (data),
    .code_o  (code_o),
    .preset_o(preset_o)
  );
endmodule

// File: rtl/qdac_serial_if_chk.sv
module qdac_serial_if_chk #(
  parameter int unsigned CH_N   = 4,
  parameter int unsigned CODE_W = 8,
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   preset_ni,
  input logic                   sclk_i,
  input logic                   ld_i,
  input logic                   sdo_o,
  input logic [CH_N*CODE_W-1:0] code_o,
  input logic [CH_N-1:0]        preset_o
);
  assert_preset_mid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preset_ni |-> code_o == {CH_N{MID}});

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && $past(ld_i) && preset_ni && $past(preset_ni)) |-> $stable(code_o));

  assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && $past(!ld_i)) |-> $stable(sdo_o));

  assert_no_edge_no_shift_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(ld_i) && $past(sclk_i) && !$past(sclk_i, 2)) |-> $stable(sdo_o));

  assert_flag_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_ni && $past(preset_ni)) |-> (preset_o & ~$past(preset_o)) == '0);
endmodule

bind qdac_serial_if qdac_serial_if_chk #(.CH_N(CH_N), .CODE_W(CODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .preset_ni(preset_ni),
  .sclk_i   (sclk_i),
  .ld_i     (ld_i),
  .sdo_o    (sdo_o),
  .code_o   (code_o),
  .preset_o (preset_o)
);

// File: tb/tb_qdac_serial_if.sv
module tb_qdac_serial_if;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        preset_ni = 1'b1;
  logic        sclk_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic        ld_i = 1'b1;
  logic        sdo_o, sdo_oe_o;
  logic [31:0] code_o;
  logic [3:0]  preset_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_code [4];
  logic [3:0] exp_flag;

  localparam logic [11:0] VEC [8] = '{
    12'h0A5, 12'h15A, 12'h2FF, 12'h300,
    12'hC01, 12'h9FE, 12'h67E, 12'hF81
  };

  always #2 clk = ~clk;

  qdac_serial_if dut (
    .clk_i(clk), .rst_ni(rst_ni), .preset_ni(preset_ni), .sclk_i(sclk_i),
    .sdi_i(sdi_i), .ld_i(ld_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .code_o(code_o), .preset_o(preset_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi_i = b; sclk_i = 1'b0; tick(); tick();
    sclk_i = 1'b1; tick(); tick();
  endtask

  task automatic send_frame(input logic [11:0] f);
    for (int i = 11; i >= 0; i--) send_bit(f[i]);
  endtask

  function automatic logic [31:0] exp_bus();
    return {exp_code[3], exp_code[2], exp_code[1], exp_code[0]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) exp_code[i] = 8'h80;
    exp_flag = 4'hF;
  endtask

  task automatic load(input logic [11:0] f, input string req);
    logic [31:0] tmp;
    tmp = exp_bus();
    tmp[f[9:8]*8 +: 8] = f[7:0];
    ld_i = 1'b0; tick();
    chk({req, " transparent"}, code_o, tmp);
    chk("R6 oe low", {31'd0, sdo_oe_o}, 32'd0);
    ld_i = 1'b1; tick(); tick();
    exp_code[f[9:8]] = f[7:0];
    exp_flag[f[9:8]] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] f;
    model_reset();
    tick(); tick(); tick();
    rst_ni = 1'b1; tick();
    // R1 reset state
    chk("R1 codes", code_o, 32'h80808080);
    chk("R1 flags", {28'd0, preset_o}, 32'hF);
    chk("R1 sdo", {31'd0, sdo_o}, 32'd0);
    chk("R2 oe high", {31'd0, sdo_oe_o}, 32'd1);

    // table walk: R2 R3 R4 R5 R8
    for (int v = 0; v < 8; v++) begin
      send_frame(VEC[v]);
      chk("R2 sdo msb", {31'd0, sdo_o}, {31'd0, VEC[v][11]});
      load(VEC[v], "R4 R3");
      chk("R5 hold", code_o, exp_bus());
      chk("R8 flags", {28'd0, preset_o}, {28'd0, exp_flag});
    end

    // R6: clocks and data during low strobe are ignored
    f = 12'h6A5;
    send_frame(f);
    ld_i = 1'b0; tick();
    for (int k = 0; k < 6; k++) begin
      sdi_i = ~sdi_i; sclk_i = 1'b0; tick(); sclk_i = 1'b1; tick();
    end
    chk("R6 code frozen", {24'd0, code_o[23:16]}, 32'hA5);
    sclk_i = 1'b0; ld_i = 1'b1; tick(); tick();
    exp_code[2] = 8'hA5; exp_flag[2] = 1'b0;
    chk("R6 sdo msb kept", {31'd0, sdo_o}, {31'd0, f[11]});
    for (int k = 1; k < 12; k++) begin
      send_bit(1'b0);
      chk("R6 R2 readback", {31'd0, sdo_o}, {31'd0, f[11-k]});
    end
    chk("R5 codes after traffic", code_o, exp_bus());

    // R9: held serial clock gives one shift
    f = 12'h5C3;
    send_frame(f);
    sclk_i = 1'b0; tick(); tick();
    sclk_i = 1'b1;
    for (int k = 0; k < 10; k++) begin sdi_i = k[0]; tick(); end
    chk("R9 one shift", {31'd0, sdo_o}, {31'd0, f[10]});
    sclk_i = 1'b0; tick(); sclk_i = 1'b1; tick(); tick();
    chk("R9 next shift", {31'd0, sdo_o}, {31'd0, f[9]});

    // R7: preset with strobe high
    preset_ni = 1'b0; #1;
    chk("R7 async codes", code_o, 32'h80808080);
    tick();
    chk("R7 flags", {28'd0, preset_o}, 32'hF);
    preset_ni = 1'b1; tick(); tick();
    model_reset();
    chk("R7 kept after release", code_o, 32'h80808080);
    chk("R8 flags after preset", {28'd0, preset_o}, 32'hF);

    // R7: preset beats a transparent channel
    send_frame(12'h133);
    ld_i = 1'b0; tick();
    chk("R4 open ch1", code_o, 32'h80803380);
    preset_ni = 1'b0; tick();
    chk("R7 over transparent", code_o, 32'h80808080);
    chk("R7 flags over transparent", {28'd0, preset_o}, 32'hF);
    preset_ni = 1'b1; tick();
    ld_i = 1'b1; tick(); tick();
    exp_code[1] = 8'h33; exp_flag[1] = 1'b0;
    chk("R5 after preset load", code_o, exp_bus());

    // R1: reset mid-run
    rst_ni = 1'b0; tick();
    rst_ni = 1'b1; tick();
    model_reset();
    chk("R1 reset again", code_o, exp_bus());
    chk("R1 sdo cleared", {31'd0, sdo_o}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule